// File: doc/BRIEF.md
# Conversion Stage Sequencer with Power Modes

This block drives a single shared capacitance converter through an ordered list of conversion stages. Each stage presents its own sensor-connection pattern to the front end and issues one start request, then waits for the converter's done strobe before it moves to the next stage. When the programmed final stage has completed, the sequence boundary is reached and a new sequence begins.

Two power modes govern what happens at a boundary. In full power mode the next sequence starts in the same cycle the previous one ends. In low power mode the sequencer sleeps for a coded interval between sequences. The block leaves full power mode by itself once no touch has been reported for a programmable number of ticks, and it returns to full power mode at the first boundary after a touch is seen. All time intervals are counted in ticks from an internal prescaler, so a simulation can use a short tick while silicon uses a long one. The configuration inputs are sampled once per sequence, at its start.

Top module: `conv_stage_sequencer`

## Requirements
- R1: While reset is held, conv_start, stage_done, seq_done and low_power are all 0. After reset is released the first conv_start, for stage 0, appears within four clock cycles, in full power mode.
- R2: Stages run in increasing order from 0 up to the final stage. Exactly one conv_start is issued per stage, and the next one is issued only after conv_done for the current stage.
- R3: The final stage is cfg_last_stage when that value is at most NUM_STAGES-1, and NUM_STAGES-1 otherwise. stage_done_idx never exceeds NUM_STAGES-1.
- R4: While conv_start is high, conv_conn equals bits [16k+15:16k] of the latched cfg_conn for stage k. Within that word, sensor input i uses bits [2i+1:2i]: 00 open, 01 negative converter input, 10 positive converter input, 11 bias. conv_decim_256 equals the latched cfg_decim_256 (0 selects decimation 128, 1 selects 256).
- R5: stage_done pulses for one cycle, in the cycle after conv_done is seen, with stage_done_idx set to the completed stage. seq_done pulses in that same cycle when the completed stage is the final stage, and not otherwise.
- R6: In full power mode, conv_start for stage 0 of the next sequence is high in the same cycle as seq_done.
- R7: When low_power is 1 in the seq_done cycle, the next conv_start follows exactly (cfg_lp_delay+1)·SLEEP_TICKS·TICK_DIV cycles later. The delay codes 0, 1, 2 and 3 stand for one, two, three and four sleep units.
- R8: The block enters low power at a sequence boundary at which touch_active is 0 and at least cfg_idle_timeout ticks have passed since touch_active was last 1. While touch_active is held at 1 it never enters low power, even with a timeout of 0. low_power changes only in a seq_done cycle.
- R9: A touch_active pulse seen at any point in low power mode, including during the sleep, switches the block to full power at the next sequence boundary, and that boundary inserts no sleep. Until that boundary low_power stays 1.
- R10: Configuration inputs are sampled only when a sequence starts. Changes made while a sequence is running do not alter that sequence's stage count, patterns, decimation, sleep code or timeout.
- R11: conv_start is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_last_stage | input | 4 | Final stage number of a sequence |
| cfg_conn | input | 192 | Connection words for the stages, 16 bits per stage |
| cfg_lp_delay | input | 2 | Sleep code used between sequences in low power mode |
| cfg_idle_timeout | input | 8 | Number of ticks without touch before entering low power |
| cfg_decim_256 | input | 1 | Decimation select, 1 for 256 and 0 for 128 |
| touch_active | input | 1 | A sensor is currently touched |
| conv_done | input | 1 | The converter has finished the current conversion |
| conv_start | output | 1 | One-cycle conversion start request |
| conv_stage | output | 4 | Number of the active stage |
| conv_conn | output | 16 | Connection word of the active stage |
| conv_decim_256 | output | 1 | Decimation select sent to the converter |
| stage_done | output | 1 | Pulse when a stage completes |
| stage_done_idx | output | 4 | Number of the completed stage |
| seq_done | output | 1 | Pulse when the final stage completes |
| low_power | output | 1 | 1 while the block is in low power mode |

## Verification
A corrupted stage counter or final-stage latch shows at once: the next conv_start carries the wrong conv_stage or conv_conn, or seq_done appears on the wrong stage_done pulse, within one stage. A wrong power mode or sleep counter shows at the next sequence boundary, as a gap between seq_done and the next conv_start that differs from the gap expected for the current mode and sleep code. A faulty idle counter or wake flag shows as low_power switching at the wrong boundary, within one timeout plus one sequence.

// File: rtl/seq_pkg.sv
package seq_pkg;
    typedef enum logic [1:0] {
        ST_BOOT   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_WAIT   = 2'd2,
        ST_SLEEP  = 2'd3
    } seq_state_e;

    typedef enum logic {
        PM_FULL = 1'b0,
        PM_LOW  = 1'b1
    } pwr_mode_e;
endpackage

// File: rtl/seq_tick_gen.sv
module seq_tick_gen #(
    parameter int TICK_DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q + CW'(1);
        if (clr || tick) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // no tick may follow a clear directly unless the divider is one cycle
    p_tick_after_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && TICK_DIV > 1) |=> !tick);
endmodule

// File: rtl/seq_conn_select.sv
module seq_conn_select #(
    parameter int NUM_STAGES = 12,
    parameter int CONN_W     = 16,
    parameter int STG_W      = 4
) (
    input  logic [NUM_STAGES*CONN_W-1:0] conn_all,
    input  logic [STG_W-1:0]             sel,
    output logic [CONN_W-1:0]            conn
);
    logic [CONN_W-1:0] words [NUM_STAGES];

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_word
        assign words[g] = conn_all[g*CONN_W +: CONN_W];
    end

    always_comb begin
        conn = '0;
        for (int k = 0; k < NUM_STAGES; k++) begin
            if (sel == STG_W'(k)) conn = words[k];
        end
    end
endmodule

// File: rtl/conv_stage_sequencer.sv
module conv_stage_sequencer
    import seq_pkg::*;
#(
    parameter int NUM_STAGES  = 12,
    parameter int NUM_INPUTS  = 8,
    parameter int TICK_DIV    = 16,
    parameter int SLEEP_TICKS = 10,
    parameter int TO_W        = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [$clog2(NUM_STAGES)-1:0]         cfg_last_stage,
    input  logic [NUM_STAGES*2*NUM_INPUTS-1:0]    cfg_conn,
    input  logic [1:0]                            cfg_lp_delay,
    input  logic [TO_W-1:0]                       cfg_idle_timeout,
    input  logic                                  cfg_decim_256,
    input  logic                                  touch_active,
    input  logic                                  conv_done,
    output logic                                  conv_start,
    output logic [$clog2(NUM_STAGES)-1:0]         conv_stage,
    output logic [2*NUM_INPUTS-1:0]               conv_conn,
    output logic                                  conv_decim_256,
    output logic                                  stage_done,
    output logic [$clog2(NUM_STAGES)-1:0]         stage_done_idx,
    output logic                                  seq_done,
    output logic                                  low_power
);
    localparam int STG_W    = $clog2(NUM_STAGES);
    localparam int CONN_W   = 2 * NUM_INPUTS;
    localparam int CONN_ALL = NUM_STAGES * CONN_W;
    localparam int SLP_W    = $clog2(4 * SLEEP_TICKS + 1);
    localparam logic [STG_W-1:0] MAX_STG = STG_W'(NUM_STAGES - 1);

    typedef struct packed {
        seq_state_e          st;
        pwr_mode_e           mode;
        logic [STG_W-1:0]    stage;
        logic [STG_W-1:0]    last;
        logic [CONN_ALL-1:0] conn;
        logic [1:0]          dly;
        logic [TO_W-1:0]     tmo;
        logic                decim;
        logic [TO_W-1:0]     idle;
        logic                wake;
        logic [SLP_W-1:0]    slp;
        logic                stage_done;
        logic [STG_W-1:0]    done_idx;
        logic                seq_done;
    } seq_reg_t;

    seq_reg_t r_d, r_q;
    logic     tick;
    logic     tick_clr;
    logic     load_cfg;
    logic [SLP_W-1:0] sleep_tgt;

    seq_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tick_clr),
        .tick  (tick)
    );

    seq_conn_select #(
        .NUM_STAGES (NUM_STAGES),
        .CONN_W     (CONN_W),
        .STG_W      (STG_W)
    ) u_sel (
        .conn_all (r_q.conn),
        .sel      (r_q.stage),
        .conn     (conv_conn)
    );

    assign sleep_tgt = SLP_W'(({30'd0, r_q.dly} + 32'd1) * SLEEP_TICKS);

    always_comb begin
        r_d            = r_q;
        r_d.stage_done = 1'b0;
        r_d.seq_done   = 1'b0;
        load_cfg       = 1'b0;
        tick_clr       = 1'b0;

        // touch tracking per mode
        if (r_q.mode == PM_FULL) begin
            if (touch_active)                 r_d.idle = '0;
            else if (tick && r_q.idle != '1)  r_d.idle = r_q.idle + TO_W'(1);
        end else if (touch_active) begin
            r_d.wake = 1'b1;
        end

        case (r_q.st)
            ST_BOOT: begin
                r_d.st    = ST_LAUNCH;
                r_d.stage = '0;
                load_cfg  = 1'b1;
            end
            ST_LAUNCH: r_d.st = ST_WAIT;
            ST_WAIT: begin
                if (conv_done) begin
                    r_d.stage_done = 1'b1;
                    r_d.done_idx   = r_q.stage;
                    if (r_q.stage == r_q.last) begin
                        r_d.seq_done = 1'b1;
                        r_d.stage    = '0;
                        if (r_q.mode == PM_FULL) begin
                            if (!touch_active && r_q.idle >= r_q.tmo) begin
                                r_d.mode = PM_LOW;
                                r_d.wake = 1'b0;
                                r_d.st   = ST_SLEEP;
                                r_d.slp  = '0;
                                tick_clr = 1'b1;
                            end else begin
                                r_d.st   = ST_LAUNCH;
                                load_cfg = 1'b1;
                            end
                        end else if (r_q.wake || touch_active) begin
                            r_d.mode = PM_FULL;
                            r_d.idle = '0;
                            r_d.wake = 1'b0;
                            r_d.st   = ST_LAUNCH;
                            load_cfg = 1'b1;
                        end else begin
                            r_d.st   = ST_SLEEP;
                            r_d.slp  = '0;
                            tick_clr = 1'b1;
                        end
                    end else begin
                        r_d.stage = r_q.stage + STG_W'(1);
                        r_d.st    = ST_LAUNCH;
                    end
                end
            end
            ST_SLEEP: begin
                if (tick) begin
                    if (r_q.slp == sleep_tgt - SLP_W'(1)) begin
                        r_d.st   = ST_LAUNCH;
                        load_cfg = 1'b1;
                    end else begin
                        r_d.slp = r_q.slp + SLP_W'(1);
                    end
                end
            end
            default: r_d.st = ST_BOOT;
        endcase

        if (load_cfg) begin
            r_d.last  = (cfg_last_stage > MAX_STG) ? MAX_STG : cfg_last_stage;
            r_d.conn  = cfg_conn;
            r_d.dly   = cfg_lp_delay;
            r_d.tmo   = cfg_idle_timeout;
            r_d.decim = cfg_decim_256;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign conv_start     = (r_q.st == ST_LAUNCH);
    assign conv_stage     = r_q.stage;
    assign conv_decim_256 = r_q.decim;
    assign stage_done     = r_q.stage_done;
    assign stage_done_idx = r_q.done_idx;
    assign seq_done       = r_q.seq_done;
    assign low_power      = (r_q.mode == PM_LOW);

    p_start_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    p_seq_with_stage_r5: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> stage_done);
    p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stage_done |-> (stage_done_idx <= MAX_STG));
    p_sleep_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && low_power) |-> !conv_start);
    p_full_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && !low_power) |-> (conv_start && conv_stage == '0));
    p_mode_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (low_power != $past(low_power)) |-> seq_done);
    p_no_start_while_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_done && !seq_done) |-> conv_start);
endmodule

// File: tb/sim_conv_stage_sequencer.sv
`timescale 1ns/1ps
module sim_conv_stage_sequencer;
    localparam int NS   = 12;
    localparam int NI   = 8;
    localparam int DIV  = 4;
    localparam int SLT  = 5;
    localparam int CW   = 2 * NI;
    localparam int CALL = NS * CW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0]      cfg_last_stage = '0;
    logic [CALL-1:0] cfg_conn = '0;
    logic [1:0]      cfg_lp_delay = '0;
    logic [7:0]      cfg_idle_timeout = '0;
    logic            cfg_decim_256 = 1'b0;
    logic            touch_active = 1'b0;
    logic            conv_done;
    logic            conv_start;
    logic [3:0]      conv_stage;
    logic [CW-1:0]   conv_conn;
    logic            conv_decim_256;
    logic            stage_done;
    logic [3:0]      stage_done_idx;
    logic            seq_done;
    logic            low_power;

    always #2 clk = ~clk;

    conv_stage_sequencer #(
        .NUM_STAGES(NS), .NUM_INPUTS(NI), .TICK_DIV(DIV),
        .SLEEP_TICKS(SLT), .TO_W(8)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_last_stage(cfg_last_stage),
        .cfg_conn(cfg_conn), .cfg_lp_delay(cfg_lp_delay),
        .cfg_idle_timeout(cfg_idle_timeout), .cfg_decim_256(cfg_decim_256),
        .touch_active(touch_active), .conv_done(conv_done),
        .conv_start(conv_start), .conv_stage(conv_stage), .conv_conn(conv_conn),
        .conv_decim_256(conv_decim_256), .stage_done(stage_done),
        .stage_done_idx(stage_done_idx), .seq_done(seq_done), .low_power(low_power)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [3:0] clamp_last(input logic [3:0] l);
        return (l > 4'(NS - 1)) ? 4'(NS - 1) : l;
    endfunction

    function automatic logic [CW-1:0] word_of(input logic [CALL-1:0] c, input int s);
        return c[s*CW +: CW];
    endfunction

    function automatic int sleep_cycles(input logic [1:0] code);
        return (int'(code) + 1) * SLT * DIV;
    endfunction

    // converter model: done strobe a fixed number of cycles after a start
    initial begin
        conv_done = 1'b0;
        @(posedge clk); #1;
        forever begin
            if (rst_n && conv_start) begin
                repeat (conv_decim_256 ? 5 : 3) @(posedge clk);
                #1 conv_done = 1'b1;
                @(posedge clk);
                #1 conv_done = 1'b0;
            end else begin
                @(posedge clk); #1;
            end
        end
    end

    // monitor
    logic [3:0]      exp_stage, run_stage, act_last, snap_last;
    logic [CALL-1:0] act_conn, snap_conn;
    logic            act_decim, snap_decim;
    logic [1:0]      act_dly, snap_dly;
    logic            prev_done, prev_start, gap_pending;
    int              seq_cyc, gap_exp;

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            exp_stage = '0; run_stage = '0; prev_done = 1'b0; prev_start = 1'b0;
            gap_pending = 1'b0; act_last = '0; act_conn = '0; act_decim = 1'b0; act_dly = '0;
        end else begin
            if (prev_done) begin
                chk(stage_done && stage_done_idx == run_stage, "R5 stage_done/idx",
                    {stage_done, stage_done_idx}, {1'b1, run_stage});
                if (run_stage == act_last) begin
                    chk(seq_done, "R5 seq_done on final stage", seq_done, 1);
                    exp_stage   = '0;
                    gap_pending = 1'b1;
                    gap_exp     = low_power ? sleep_cycles(act_dly) : 0;
                    seq_cyc     = cyc;
                end else begin
                    chk(!seq_done, "R5 no seq_done mid-sequence", seq_done, 0);
                    exp_stage = run_stage + 4'd1;
                end
            end else if (stage_done) begin
                chk(1'b0, "R5 stray stage_done", stage_done, 0);
            end
            if (conv_start) begin
                chk(!prev_start, "R11 start pulse width", prev_start, 0);
                if (exp_stage == 4'd0) begin
                    act_last  = clamp_last(snap_last);
                    act_conn  = snap_conn;
                    act_decim = snap_decim;
                    act_dly   = snap_dly;
                    if (gap_pending) begin
                        chk(cyc - seq_cyc == gap_exp,
                            gap_exp == 0 ? "R6 full power gap" : "R7 low power sleep gap",
                            64'(cyc - seq_cyc), 64'(gap_exp));
                        gap_pending = 1'b0;
                    end
                end
                chk(conv_stage == exp_stage, "R2 stage order", conv_stage, exp_stage);
                chk(conv_conn == word_of(act_conn, int'(conv_stage)), "R4 R10 connection word",
                    conv_conn, word_of(act_conn, int'(conv_stage)));
                chk(conv_decim_256 == act_decim, "R4 R10 decimation", conv_decim_256, act_decim);
                run_stage = conv_stage;
            end
        end
        prev_done  = conv_done;
        prev_start = conv_start;
        snap_last  = cfg_last_stage;
        snap_conn  = cfg_conn;
        snap_decim = cfg_decim_256;
        snap_dly   = cfg_lp_delay;
    end

    task automatic rand_cfg();
        logic [CALL-1:0] c;
        for (int w = 0; w < CALL / 32; w++) c[w*32 +: 32] = $urandom;
        cfg_conn       = c;
        cfg_last_stage = 4'($urandom % 16);
        cfg_decim_256  = 1'($urandom % 2);
        cfg_lp_delay   = 2'($urandom % 4);
    endtask

    task automatic wait_seq_done();
        do @(negedge clk); while (!seq_done);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            summary();
        end
    end

    initial begin
        int rel_cyc;
        int rise_cyc;
        bit seen;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!conv_start && !stage_done && !seq_done && !low_power, "R1 reset outputs",
            {conv_start, stage_done, seq_done, low_power}, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 4 && !seen; i++) begin
            @(negedge clk);
            if (conv_start) seen = 1'b1;
        end
        chk(seen && conv_stage == 0 && !low_power, "R1 first start after reset",
            {seen, conv_stage, low_power}, {1'b1, 4'd0, 1'b0});

        // touch held, random configuration changes at random times
        @(posedge clk); #1 touch_active = 1'b1; cfg_idle_timeout = 8'd0;
        for (int k = 0; k < 30; k++) begin
            rand_cfg();
            if (k == 3) cfg_last_stage = 4'd15;
            if (k == 4) cfg_last_stage = 4'd11;
            repeat (20 + ($urandom % 180)) @(posedge clk);
            #1;
        end
        @(negedge clk);
        chk(!low_power, "R8 touch held keeps full power", low_power, 0);

        // idle timeout entry
        @(posedge clk); #1 cfg_last_stage = 4'd11; cfg_decim_256 = 1'b1; cfg_idle_timeout = 8'd6;
        cfg_lp_delay = 2'd0;
        repeat (300) @(posedge clk);
        #1 touch_active = 1'b0;
        rel_cyc = cyc;
        do @(negedge clk); while (!low_power);
        rise_cyc = cyc;
        chk(rise_cyc - rel_cyc >= 5 * DIV, "R8 timeout not early", 64'(rise_cyc - rel_cyc), 64'(5 * DIV));
        chk(rise_cyc - rel_cyc <= 7 * DIV + 120, "R8 timeout not late", 64'(rise_cyc - rel_cyc), 64'(7 * DIV + 120));
        chk(seq_done, "R8 mode changes at boundary", seq_done, 1);

        // sleep codes in low power
        @(posedge clk); #1 cfg_last_stage = 4'd1; cfg_decim_256 = 1'b0;
        for (int code = 0; code < 4; code++) begin
            @(posedge clk); #1 cfg_lp_delay = 2'(code);
            repeat (3) wait_seq_done();
            chk(low_power, "R7 stays in low power", low_power, 1);
        end

        // wake from a touch pulse during sleep
        do wait_seq_done(); while (!low_power);
        repeat (5) @(posedge clk);
        #1 touch_active = 1'b1; cfg_idle_timeout = 8'd255;
        @(posedge clk); #1 touch_active = 1'b0;
        @(negedge clk);
        chk(low_power, "R9 no wake before boundary", low_power, 1);
        wait_seq_done();
        chk(!low_power, "R9 wake at boundary", low_power, 0);
        repeat (200) @(negedge clk);
        chk(!low_power, "R9 stays in full power", low_power, 0);

        finished = 1'b1;
        summary();
    end
endmodule